// File: doc/BRIEF.md
# Strobe-Driven Multi-Queue Read Port

This block lets an external host pull words out of several internal queues using three asynchronous active-low strobes: a select (`cs_n`), a bus-drive enable (`oe_n`) and a fetch strobe (`rd_n`). A 2-bit queue address (`fadr`) picks the queue. The strobes and the address pass through two-flop synchronizers into the block clock. A small state machine then decides when the shared tri-state data bus is driven and when a word is taken from the chosen queue.

The bus shows a held word, not the queue head. Driving the enable alone puts the last fetched word on the bus. Each fetch strobe that lands while the select is active copies the head of the selected queue into the hold register and advances that queue's read pointer. A burst of strobe pulses therefore presents words N, N+1, N+2 in turn. An internal write port fills the queues. Per-queue empty and full flags are visible to the host.

The state machine has four states:
- `ST_IDLE`: the bus is released and no fetch is in progress.
- `ST_SHOW`: the bus carries the held word and no fetch is in progress.
- `ST_READ_DRV`: a fetch is in progress and the bus is driven.
- `ST_READ_HID`: a fetch is in progress and the bus is released.

Transitions are evaluated on the synchronized strobes:
- From `ST_IDLE` or `ST_SHOW`, the state goes to `ST_READ_DRV` or `ST_READ_HID` when select and fetch are both active. The choice follows the enable. Otherwise the state goes to `ST_SHOW` or `ST_IDLE`, again following the enable.
- From either read state, the state stays in a read state while the fetch strobe is held. The choice of read state follows the enable.
- When the fetch strobe is released, the state returns to `ST_SHOW` or `ST_IDLE`, following the enable.

Top module: `strobe_fifo_rdport`

## Requirements
- R1: A synchronous active-high `rst` clears every queue pointer and the hold word to zero. After reset, `empty` is all ones, `full` is all zeros and `dq_oe` is 0.
- R2: While `wr_en` is 1, `wr_data` is appended to queue `wr_sel` unless that queue is full. A write to a full queue is dropped. A queue reports `full` after DEPTH (8) words are stored.
- R3: Every strobe and the address are sampled through two flops. A change that is set up before clock edge 1 shows at the outputs right after edge 3.
- R4: A fetch starts only when the synchronized select and fetch are both active and no fetch is in progress. With `cs_n` high, a `rd_n` pulse changes no pointer, flag or bus word.
- R5: With `oe_n` low and no new fetch, the bus carries the last fetched word. That word is 0 after reset.
- R6: A fetch from a non-empty queue latches the word at that queue's read pointer and advances the pointer by one. Each low-high cycle of `rd_n` consumes exactly one word, so a burst returns the words in write order.
- R7: `dq_oe` follows the synchronized inverse of `oe_n`, and the bus is released while `oe_n` is high. A fetch still consumes a word while the bus is released.
- R8: With `oe_n` and `rd_n` tied together, each pulse drives the newly fetched word.
- R9: A fetch from an empty queue moves no pointer, and the bus keeps the previous word.
- R10: A consumed word changes `empty` and `full` at the same clock edge that latches the word, which is edge 3 after the `rd_n` fall. Flags change only when a word is written or consumed.
- R11: Each of the four queues has its own read and write pointers. Reading one queue does not disturb another.
- R12: A fetch started in `ST_READ_HID` moves to `ST_READ_DRV` when `oe_n` falls while `rd_n` is still low. The bus then shows the word that fetch consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Internal write request |
| wr_sel | input | 2 | Queue chosen for writing |
| wr_data | input | 8 | Word to append |
| cs_n | input | 1 | Asynchronous select, active low |
| oe_n | input | 1 | Asynchronous bus-drive enable, active low |
| rd_n | input | 1 | Asynchronous fetch strobe, active low |
| fadr | input | 2 | Queue chosen for reading |
| dq | inout | 8 | Tri-state data bus |
| dq_oe | output | 1 | High while the block drives `dq` |
| empty | output | 4 | Per-queue empty flag |
| full | output | 4 | Per-queue full flag |

## Verification
The bench keeps one behavioural queue per channel and mirrors the two-stage sampling in its own model. Every cycle it compares the bus, the bus enable and all flags against that model. Directed cases cover the following, each with the failure it would expose:
- A fetch with the select high. A design that ignored the select would advance a pointer.
- A fetch from an empty queue. A wrong design would drive stale memory or corrupt the pointer.
- Enable and fetch tied together. A wrong design would show the old word or fetch twice.
- A fetch held while the enable arrives late. A wrong design would show the wrong word.
- Writes past the full mark. A wrong design would overwrite data and skew the read order.

Exact edge-count checks on the bus enable and on the empty flag expose any missing or extra synchronizer stage. A randomized phase with overlapping strobes and writes probes ordering between the write and read sides.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHOW,
        ST_READ_DRV,
        ST_READ_HID
    } rd_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/fifo_bank.sv
module fifo_bank #(
    parameter int N_FIFO     = 4,
    parameter int SEL_W      = 2,
    parameter int DATA_W     = 8,
    parameter int DEPTH_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    input  logic [SEL_W-1:0]  pop_sel,
    output logic [DATA_W-1:0] head_word,
    output logic [N_FIFO-1:0] empty,
    output logic [N_FIFO-1:0] full
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int PTR_W = DEPTH_LOG2 + 1;

    logic [DATA_W-1:0] heads [N_FIFO];

    for (genvar g = 0; g < N_FIFO; g++) begin : g_q
        logic [DATA_W-1:0] mem [DEPTH];
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic              do_wr;
        logic              do_rd;

        assign empty[g] = (wptr == rptr);
        assign full[g]  = (wptr[PTR_W-1] != rptr[PTR_W-1]) &&
                          (wptr[PTR_W-2:0] == rptr[PTR_W-2:0]);
        assign do_wr    = wr_en && (wr_sel == SEL_W'(g)) && !full[g];
        assign do_rd    = pop && (pop_sel == SEL_W'(g)) && !empty[g];
        assign heads[g] = mem[rptr[PTR_W-2:0]];

        always_ff @(posedge clk) begin
            if (do_wr) begin
                mem[wptr[PTR_W-2:0]] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (do_wr) wptr <= wptr + 1'b1;
                if (do_rd) rptr <= rptr + 1'b1;
            end
        end
    end

    assign head_word = heads[pop_sel];
endmodule

// File: rtl/rd_seq_fsm.sv
module rd_seq_fsm
    import strobe_fifo_pkg::*;
#(
    parameter int N_FIFO = 4,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_cs,
    input  logic              s_oe,
    input  logic              s_rd,
    input  logic [SEL_W-1:0]  s_sel,
    input  logic [DATA_W-1:0] head_word,
    input  logic [N_FIFO-1:0] empty,
    output logic              pop,
    output logic [DATA_W-1:0] hold_word,
    output logic              bus_en
);
    rd_state_e state_q;
    rd_state_e state_d;
    logic      rd_go;
    logic      start;

    assign rd_go = s_cs && s_rd;

    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SHOW: begin
                if (rd_go) begin
                    start   = 1'b1;
                    state_d = s_oe ? ST_READ_DRV : ST_READ_HID;
                end else begin
                    state_d = s_oe ? ST_SHOW : ST_IDLE;
                end
            end
            ST_READ_DRV, ST_READ_HID: begin
                if (s_rd) begin
                    state_d = s_oe ? ST_READ_DRV : ST_READ_HID;
                end else begin
                    state_d = s_oe ? ST_SHOW : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pop = start && !empty[s_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_word <= '0;
        end else if (pop) begin
            hold_word <= head_word;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SHOW, ST_READ_DRV: bus_en = 1'b1;
            default:              bus_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/strobe_fifo_rdport.sv
module strobe_fifo_rdport #(
    parameter int SEL_W      = 2,
    parameter int DATA_W     = 8,
    parameter int DEPTH_LOG2 = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   cs_n,
    input  logic                   oe_n,
    input  logic                   rd_n,
    input  logic [SEL_W-1:0]       fadr,
    inout  wire  [DATA_W-1:0]      dq,
    output logic                   dq_oe,
    output logic [(1<<SEL_W)-1:0]  empty,
    output logic [(1<<SEL_W)-1:0]  full
);
    localparam int N_FIFO = 1 << SEL_W;
    localparam int SYNC_W = SEL_W + 3;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{SEL_W{1'b0}}, 3'b111};

    logic [SYNC_W-1:0] sync_q;
    logic [SEL_W-1:0]  pop_sel;
    logic              s_cs, s_oe, s_rd;
    logic              pop;
    logic [DATA_W-1:0] head_word;
    logic [DATA_W-1:0] hold_word;

    strobe_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({fadr, cs_n, oe_n, rd_n}),
        .sync_out (sync_q)
    );

    assign pop_sel = sync_q[SYNC_W-1:3];
    assign s_cs    = !sync_q[2];
    assign s_oe    = !sync_q[1];
    assign s_rd    = !sync_q[0];

    fifo_bank #(
        .N_FIFO(N_FIFO), .SEL_W(SEL_W), .DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pop       (pop),
        .pop_sel   (pop_sel),
        .head_word (head_word),
        .empty     (empty),
        .full      (full)
    );

    rd_seq_fsm #(.N_FIFO(N_FIFO), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .s_cs      (s_cs),
        .s_oe      (s_oe),
        .s_rd      (s_rd),
        .s_sel     (pop_sel),
        .head_word (head_word),
        .empty     (empty),
        .pop       (pop),
        .hold_word (hold_word),
        .bus_en    (dq_oe)
    );

    assign dq = dq_oe ? hold_word : {DATA_W{1'bz}};
endmodule

// File: rtl/strobe_fifo_rdport_chk.sv
module strobe_fifo_rdport_chk #(
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  oe_n,
    input logic                  wr_en,
    input logic                  dq_oe,
    input logic [DATA_W-1:0]     dq,
    input logic [(1<<SEL_W)-1:0] empty,
    input logic [(1<<SEL_W)-1:0] full,
    input logic                  pop,
    input logic [SEL_W-1:0]      pop_sel
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> ((&empty) && (full == '0) && !dq_oe));

    a_r7_bus_follows_oe: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd3) |-> (dq_oe == !$past(oe_n, 3)));

    a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty[pop_sel]));

    a_r10_flags_quiet: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd1 && !$past(pop) && !$past(wr_en)) |-> ($stable(empty) && $stable(full)));

    a_r6_word_steady: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd1 && dq_oe && $past(dq_oe) && !$past(pop)) |-> $stable(dq));
endmodule

bind strobe_fifo_rdport strobe_fifo_rdport_chk #(.SEL_W(SEL_W), .DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (oe_n),
    .wr_en   (wr_en),
    .dq_oe   (dq_oe),
    .dq      (dq),
    .empty   (empty),
    .full    (full),
    .pop     (pop),
    .pop_sel (pop_sel)
);

// File: tb/strobe_fifo_rdport_tb_top.sv
module strobe_fifo_rdport_tb_top;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       cs_n = 1'b1, oe_n = 1'b1, rd_n = 1'b1;
    logic [1:0] fadr = '0;
    wire  [7:0] dq;
    logic       dq_oe;
    logic [3:0] empty, full;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    strobe_fifo_rdport dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cs_n(cs_n), .oe_n(oe_n), .rd_n(rd_n), .fadr(fadr),
        .dq(dq), .dq_oe(dq_oe), .empty(empty), .full(full)
    );

    // behavioural reference model
    int   mq [4][$];
    bit   m_s1cs, m_s1oe, m_s1rd, m_s2cs, m_s2oe, m_s2rd;
    int   m_s1a, m_s2a;
    bit   m_inrd, m_drv;
    int   m_hold;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) mq[i].delete();
            m_s1cs = 0; m_s1oe = 0; m_s1rd = 0;
            m_s2cs = 0; m_s2oe = 0; m_s2rd = 0;
            m_s1a = 0; m_s2a = 0;
            m_inrd = 0; m_drv = 0; m_hold = 0;
        end else begin
            bit go, take, wfull;
            go    = m_s2cs && m_s2rd;
            take  = !m_inrd && go;
            wfull = (mq[wr_sel].size() == DEPTH);
            m_inrd = m_inrd ? m_s2rd : go;
            m_drv  = m_s2oe;
            if (take && mq[m_s2a].size() > 0) m_hold = mq[m_s2a].pop_front();
            if (wr_en && !wfull) mq[wr_sel].push_back(int'(wr_data));
            m_s2cs = m_s1cs; m_s2oe = m_s1oe; m_s2rd = m_s1rd; m_s2a = m_s1a;
            m_s1cs = !cs_n;  m_s1oe = !oe_n;  m_s1rd = !rd_n;  m_s1a = int'(fadr);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (dq_oe !== m_drv) begin
                errors++;
                $display("FAIL R7 dq_oe: actual %0b expected %0b", dq_oe, m_drv);
            end
            if (m_drv) begin
                checks++;
                if (dq !== 8'(m_hold)) begin
                    errors++;
                    $display("FAIL R6 dq: actual %0h expected %0h", dq, m_hold);
                end
            end
            for (int i = 0; i < 4; i++) begin
                checks++;
                if (empty[i] !== (mq[i].size() == 0) || full[i] !== (mq[i].size() == DEPTH)) begin
                    errors++;
                    $display("FAIL R10 flags q%0d: actual e%0b f%0b expected size %0d",
                             i, empty[i], full[i], mq[i].size());
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 empty after reset", 32'(empty), 32'hF);
        check("R1 full after reset", 32'(full), 32'h0);
        check("R1 bus released", 32'(dq_oe), 32'h0);

        oe_n = 1'b0; tick(4);
        check("R5 oe alone drives", 32'(dq_oe), 32'h1);
        check("R5 reset word", 32'(dq), 32'h0);

        push(2'd1, 8'hA1); push(2'd1, 8'hA2); push(2'd1, 8'hA3); push(2'd2, 8'hB1);
        tick(1);
        check("R2 flags after writes", 32'(empty), 32'b1001);

        fadr = 2'd1; cs_n = 1'b0; tick(4);
        rd_n = 1'b0; tick(4);
        check("R6 first word", 32'(dq), 32'hA1);
        rd_n = 1'b1; tick(4);
        check("R5 oe keeps word", 32'(dq), 32'hA1);
        rd_n = 1'b0; tick(4); rd_n = 1'b1; tick(4);
        check("R6 burst second", 32'(dq), 32'hA2);
        rd_n = 1'b0; tick(4); rd_n = 1'b1; tick(4);
        check("R6 burst third", 32'(dq), 32'hA3);
        check("R10 drained flag", 32'(empty[1]), 32'h1);
        rd_n = 1'b0; tick(4); rd_n = 1'b1; tick(4);
        check("R9 empty read keeps word", 32'(dq), 32'hA3);

        fadr = 2'd2; cs_n = 1'b1; tick(4);
        rd_n = 1'b0; tick(4); rd_n = 1'b1; tick(4);
        check("R4 no select word", 32'(dq), 32'hA3);
        check("R4 no select flag", 32'(empty[2]), 32'h0);
        cs_n = 1'b0; oe_n = 1'b1; tick(4);

        oe_n = 1'b0; rd_n = 1'b0; tick(4);
        check("R8 tied strobe drive", 32'(dq_oe), 32'h1);
        check("R8 tied strobe word", 32'(dq), 32'hB1);
        oe_n = 1'b1; rd_n = 1'b1; tick(4);
        check("R7 released", 32'(dq_oe), 32'h0);

        push(2'd3, 8'hC1); push(2'd3, 8'hC2);
        fadr = 2'd3; tick(4);
        rd_n = 1'b0; tick(4);
        check("R7 hidden read", 32'(dq_oe), 32'h0);
        oe_n = 1'b0; tick(4);
        check("R12 late oe shows word", 32'(dq), 32'hC1);
        rd_n = 1'b1; tick(4);
        rd_n = 1'b0; tick(4);
        check("R11 independent pointer", 32'(dq), 32'hC2);
        rd_n = 1'b1; oe_n = 1'b1; tick(4);

        for (int i = 0; i < 9; i++) push(2'd0, 8'(i));
        tick(1);
        check("R2 full mark", 32'(full[0]), 32'h1);
        fadr = 2'd0; tick(4);
        for (int i = 0; i < 8; i++) begin
            oe_n = 1'b0; rd_n = 1'b0; tick(4);
            check("R6 order from full", 32'(dq), 32'(i));
            oe_n = 1'b1; rd_n = 1'b1; tick(4);
        end
        check("R2 ninth write dropped", 32'(empty[0]), 32'h1);

        push(2'd2, 8'hB2);
        fadr = 2'd2; tick(4);
        oe_n = 1'b0; tick(2);
        check("R3 enable after two edges", 32'(dq_oe), 32'h0);
        tick(1);
        check("R3 enable at third edge", 32'(dq_oe), 32'h1);
        tick(2);
        rd_n = 1'b0; tick(2);
        check("R10 flag before commit", 32'(empty[2]), 32'h0);
        tick(1);
        check("R10 flag at commit", 32'(empty[2]), 32'h1);
        check("R10 word at commit", 32'(dq), 32'hB2);
        rd_n = 1'b1; tick(4);

        for (int c = 0; c < 1500; c++) begin
            wr_en   = ($urandom % 3) == 0;
            wr_sel  = 2'($urandom);
            wr_data = 8'($urandom);
            if (($urandom % 4) == 0) rd_n = ~rd_n;
            if (($urandom % 6) == 0) oe_n = ~oe_n;
            if (($urandom % 9) == 0) cs_n = ~cs_n;
            if (rd_n && ($urandom % 8) == 0) fadr = 2'($urandom);
            tick(1);
        end
        wr_en = 1'b0; rd_n = 1'b1; tick(6);
        summary();
    end
endmodule